// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the word address for a synchronous burst memory. When a recognised address strobe arrives with the chip selected, it captures the external word address. The upper bits of that address stay fixed for the rest of the burst. The two low bits then step through a four-beat sequence, one beat per clock edge in which the advance input is low. A static strap picks the step order: linear (count up modulo four) or interleaved (start value XOR beat number). After the fourth beat the sequence wraps back to the captured start address, and a high advance input holds the current address so that a burst can be suspended.

Two strobes can start a burst, a processor strobe and a controller strobe, both active low. The processor strobe counts only while the first chip select is low, and it takes priority over the controller strobe when both are low. A recognised strobe while the chip is not fully selected deselects the block. A deselect drops the burst flag and leaves the address where it was. The address output is formed without a register stage from the stored upper bits, start value and beat index, so it is valid in the cycle after the capturing edge.

Top module: `burst_addr_seq`

## Requirements
- R1: A strobe recognised at a rising edge while the chip is fully selected (cs1_n=0, cs2=1, cs3_n=0) loads addr_in. After that edge addr_out equals the sampled addr_in and burst_active is 1.
- R2: The processor strobe (proc_stb_n=0) is recognised only while cs1_n=0. While cs1_n=1 it has no effect, and ctrl_stb_n alone decides the cycle. When both strobes are low with cs1_n=0, exactly one capture of addr_in takes place.
- R3: A recognised strobe while the chip is not fully selected clears burst_active and leaves addr_out unchanged.
- R4: The upper ADDR_W-CNT_W bits of addr_out change only on a capture (R1).
- R5: With order_il=0 (linear), the low bits equal the start value plus the beat index, modulo 2^CNT_W.
- R6: With order_il=1 (interleaved), the low bits equal the start value XOR the beat index.
- R7: With no recognised strobe and a burst active, adv_n=0 increments the beat index once per rising edge, and adv_n=1 holds addr_out unchanged (suspend).
- R8: After 2^CNT_W advances, addr_out returns to the captured start address.
- R9: A capture in the same cycle as adv_n=0 takes precedence: the beat index restarts at 0 and addr_out equals the new addr_in.
- R10: With no burst active and no recognised strobe, adv_n=0 leaves addr_out and burst_active unchanged.
- R11: While rst_n is low, addr_out is 0 and burst_active is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr_in | input | ADDR_W | External word address |
| proc_stb_n | input | 1 | Processor address strobe, active low, priority strobe |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Advance, active low |
| cs1_n | input | 1 | Chip select 1, active low; also gates the processor strobe |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| order_il | input | 1 | Static order strap: 1 interleaved, 0 linear |
| addr_out | output | ADDR_W | Current burst word address |
| burst_active | output | 1 | A captured burst is in progress |

## Verification
The bench builds the block with ADDR_W=12 and CNT_W=2. Twelve bits are enough to show that the upper ten bits stay intact across many wraps and strobe mixes. The two-bit counter keeps every start value, and both step orders from every start value, within reach of short directed bursts. The random phase flips the order strap only rarely, so suspend, restart, deselect and idle-advance cycles occur in both orders at many beat positions, including a strobe that lands mid-burst together with an advance.

// File: rtl/bas_pkg.sv
package bas_pkg;

  // Per-cycle command decoded from strobes, selects and advance
  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_DESEL = 2'd2,
    CMD_STEP  = 2'd3
  } bas_cmd_e;

  // Step order chosen by the strap
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } bas_order_e;

endpackage

// File: rtl/bas_strobe_qual.sv
module bas_strobe_qual
  import bas_pkg::*;
(
  input  logic     proc_stb_n,
  input  logic     ctrl_stb_n,
  input  logic     adv_n,
  input  logic     cs1_n,
  input  logic     cs2,
  input  logic     cs3_n,
  output bas_cmd_e cmd
);

  logic proc_seen;
  logic ctrl_seen;
  logic any_stb;
  logic selected;

  // The processor strobe is masked by cs1_n and wins over the controller strobe
  always_comb begin
    proc_seen = ~proc_stb_n & ~cs1_n;
    ctrl_seen = ~proc_seen & ~ctrl_stb_n;
    any_stb   = proc_seen | ctrl_seen;
    selected  = ~cs1_n & cs2 & ~cs3_n;
  end

  always_comb begin
    if (any_stb && selected) begin
      cmd = CMD_LOAD;
    end else if (any_stb) begin
      cmd = CMD_DESEL;
    end else if (!adv_n) begin
      cmd = CMD_STEP;
    end else begin
      cmd = CMD_HOLD;
    end
  end

endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr
  import bas_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  bas_cmd_e                cmd,
  input  logic [ADDR_W-1:0]       addr_in,
  output logic [ADDR_W-CNT_W-1:0] upper_q,
  output logic [CNT_W-1:0]        start_q,
  output logic [CNT_W-1:0]        beat_q,
  output logic                    active_q
);

  localparam int UP_W = ADDR_W - CNT_W;

  logic [UP_W-1:0]  upper_d;
  logic [CNT_W-1:0] start_d;
  logic [CNT_W-1:0] beat_d;
  logic             active_d;
  logic             cap_en;
  logic             beat_en;
  logic             act_en;

  // Next-state and enables
  always_comb begin
    cap_en   = (cmd == CMD_LOAD);
    beat_en  = cap_en | ((cmd == CMD_STEP) & active_q);
    act_en   = cap_en | (cmd == CMD_DESEL);
    upper_d  = addr_in[ADDR_W-1:CNT_W];
    start_d  = addr_in[CNT_W-1:0];
    beat_d   = cap_en ? '0 : beat_q + CNT_W'(1);
    active_d = cap_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
    end else if (cap_en) begin
      upper_q <= upper_d;
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (beat_en) begin
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
    end else if (act_en) begin
      active_q <= active_d;
    end
  end

endmodule

// File: rtl/bas_addr_form.sv
module bas_addr_form
  import bas_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  bas_order_e              order,
  input  logic [ADDR_W-CNT_W-1:0] upper_q,
  input  logic [CNT_W-1:0]        start_q,
  input  logic [CNT_W-1:0]        beat_q,
  output logic [ADDR_W-1:0]       addr
);

  logic [CNT_W-1:0] low_il;
  logic [CNT_W-1:0] low_lin;
  logic [CNT_W-1:0] low_sel;

  // Interleaved order: each low bit flips with the matching beat bit
  for (genvar b = 0; b < CNT_W; b++) begin : g_il_bit
    assign low_il[b] = start_q[b] ^ beat_q[b];
  end

  // Linear order: wrapping sum
  assign low_lin = start_q + beat_q;

  always_comb begin
    unique case (order)
      ORD_INTERLEAVE: low_sel = low_il;
      default:        low_sel = low_lin;
    endcase
    addr = {upper_q, low_sel};
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bas_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              adv_n,
  input  logic              cs1_n,
  input  logic              cs2,
  input  logic              cs3_n,
  input  logic              order_il,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_active
);

  localparam int UP_W = ADDR_W - CNT_W;

  bas_cmd_e         cmd;
  bas_order_e       order;
  logic [UP_W-1:0]  upper_q;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] beat_q;
  logic             active_q;

  assign order = bas_order_e'(order_il);

  bas_strobe_qual u_qual (
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .adv_n      (adv_n),
    .cs1_n      (cs1_n),
    .cs2        (cs2),
    .cs3_n      (cs3_n),
    .cmd        (cmd)
  );

  bas_beat_ctr #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .addr_in  (addr_in),
    .upper_q  (upper_q),
    .start_q  (start_q),
    .beat_q   (beat_q),
    .active_q (active_q)
  );

  bas_addr_form #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_form (
    .order   (order),
    .upper_q (upper_q),
    .start_q (start_q),
    .beat_q  (beat_q),
    .addr    (addr_out)
  );

  assign burst_active = active_q;

endmodule

// File: rtl/bas_chk.sv
module bas_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              proc_stb_n,
  input logic              ctrl_stb_n,
  input logic              adv_n,
  input logic              cs1_n,
  input logic              cs2,
  input logic              cs3_n,
  input logic              order_il,
  input logic [ADDR_W-1:0] addr_out,
  input logic              burst_active
);

  logic en_all;
  logic stb;

  assign en_all = ~cs1_n & cs2 & ~cs3_n;
  assign stb    = (~proc_stb_n & ~cs1_n) | ~ctrl_stb_n;

  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (addr_out == '0 && !burst_active); // R11
    end
  end

  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && en_all) |=> (addr_out == $past(addr_in) && burst_active)); // R1

  AST_CE1_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (!proc_stb_n && cs1_n && ctrl_stb_n && adv_n) |=> $stable(burst_active)); // R2

  AST_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !en_all) |=> !burst_active); // R3

  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(stb && en_all) |=> (addr_out[ADDR_W-1:CNT_W] == $past(addr_out[ADDR_W-1:CNT_W]))); // R4

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb && !adv_n && burst_active && !order_il) |=>
      (order_il || addr_out[CNT_W-1:0] == CNT_W'($past(addr_out[CNT_W-1:0]) + 1'b1))); // R5

  AST_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb && adv_n) |=> ((order_il != $past(order_il)) || $stable(addr_out))); // R7

  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && en_all && !adv_n) |=> (addr_out == $past(addr_in))); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb && !burst_active) |=>
      (!burst_active && ((order_il != $past(order_il)) || $stable(addr_out)))); // R10

endmodule

bind burst_addr_seq bas_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr_in      (addr_in),
  .proc_stb_n   (proc_stb_n),
  .ctrl_stb_n   (ctrl_stb_n),
  .adv_n        (adv_n),
  .cs1_n        (cs1_n),
  .cs2          (cs2),
  .cs3_n        (cs3_n),
  .order_il     (order_il),
  .addr_out     (addr_out),
  .burst_active (burst_active)
);

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;

  localparam int AW = 12;
  localparam int CW = 2;
  localparam int UW = AW - CW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_in;
  logic          proc_stb_n, ctrl_stb_n, adv_n, cs1_n, cs2, cs3_n, order_il;
  logic [AW-1:0] addr_out;
  logic          burst_active;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // Reference state
  logic [UW-1:0] m_up;
  logic [CW-1:0] m_st, m_ix;
  logic          m_act;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .CNT_W(CW)) u0 (
    .clk (clk), .rst_n (rst_n), .addr_in (addr_in),
    .proc_stb_n (proc_stb_n), .ctrl_stb_n (ctrl_stb_n), .adv_n (adv_n),
    .cs1_n (cs1_n), .cs2 (cs2), .cs3_n (cs3_n), .order_il (order_il),
    .addr_out (addr_out), .burst_active (burst_active)
  );

  function automatic logic [AW-1:0] exp_addr();
    logic [CW-1:0] lo;
    lo = order_il ? (m_st ^ m_ix) : CW'(m_st + m_ix);
    return {m_up, lo};
  endfunction

  task automatic chk_addr(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s addr_out actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s burst_active actual %b expected %b", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, update the reference, compare at the next falling edge
  task automatic cyc(input logic [AW-1:0] a, input logic p, input logic c, input logic adv,
                     input logic c1, input logic c2, input logic c3, input string tag);
    logic  p_seen, strobe, en;
    string t;
    addr_in = a; proc_stb_n = p; ctrl_stb_n = c; adv_n = adv;
    cs1_n = c1; cs2 = c2; cs3_n = c3;
    p_seen = !p && !c1;
    strobe = p_seen || !c;
    en     = !c1 && c2 && !c3;
    @(posedge clk);
    if (strobe && en) begin
      m_up = a[AW-1:CW]; m_st = a[CW-1:0]; m_ix = '0; m_act = 1'b1; t = "R1";
    end else if (strobe) begin
      m_act = 1'b0; t = "R3";
    end else if (!adv && m_act) begin
      m_ix = m_ix + 1'b1; t = order_il ? "R6" : "R5";
    end else if (!adv) begin
      t = "R10";
    end else begin
      t = "R7";
    end
    if (tag != "") t = tag;
    @(negedge clk);
    chk_addr(t, addr_out, exp_addr());
    chk_bit(t, burst_active, m_act);
  endtask

  task automatic load(input logic [AW-1:0] a);
    cyc(a, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R1");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'd1234));
    rst_n = 1'b0; addr_in = '0; proc_stb_n = 1'b1; ctrl_stb_n = 1'b1; adv_n = 1'b1;
    cs1_n = 1'b1; cs2 = 1'b0; cs3_n = 1'b1; order_il = 1'b1;
    m_up = '0; m_st = '0; m_ix = '0; m_act = 1'b0;
    repeat (2) @(negedge clk);
    // R11: reset state
    chk_addr("R11", addr_out, '0);
    chk_bit("R11", burst_active, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // Full bursts from every start value in both orders, ending on the wrap
    for (int o = 0; o < 2; o++) begin
      order_il = o[0];
      for (int s = 0; s < 4; s++) begin
        a = {UW'($urandom), CW'(s)};
        load(a);
        for (int k = 0; k < 3; k++)
          cyc(a, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, o[0] ? "R6" : "R5");
        cyc(a, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        chk_addr("R8", addr_out, a);
      end
    end

    // Suspend mid-burst, then resume (R7)
    order_il = 1'b0;
    load(12'h5A2);
    cyc('0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
    repeat (3) cyc('1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
    cyc('0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R7");

    // Processor strobe with cs1_n high is ignored, even with selects otherwise on (R2)
    cyc(12'hFFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
    cyc(12'hFFF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R2");
    // Both strobes low, chip selected: one capture (R2)
    cyc(12'h3C1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
    // Both low with cs1_n high: controller strobe decides, chip not selected (R2)
    cyc(12'h777, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
    // Idle advance has no effect (R10)
    repeat (2) cyc('0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R10");

    // Deselect through cs2 and cs3_n (R3)
    load(12'h246);
    cyc(12'h999, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3");
    load(12'h246);
    cyc(12'h999, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R3");

    // Strobe together with advance mid-burst restarts (R9)
    order_il = 1'b1;
    load(12'h103);
    cyc('0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    cyc(12'h8B1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R9");
    cyc('0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, "R6");
    chk_addr("R4", addr_out[AW-1:CW] == 10'h22C ? addr_out : '0, addr_out);

    // Random phase
    for (int i = 0; i < 3000; i++) begin
      logic en;
      if ($urandom_range(99) == 0) order_il = ~order_il;
      en = ($urandom_range(9) != 0);
      cyc(AW'($urandom),
          ($urandom_range(4) != 0), ($urandom_range(4) != 0), ($urandom_range(9) < 4),
          en ? 1'b0 : 1'($urandom), en ? 1'b1 : 1'($urandom), en ? 1'b0 : 1'($urandom), "");
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule